// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets a synchronous master reach an asynchronous static RAM with 128K words of 8 bits. The master raises `req_valid` with `req_write`, a 17-bit address and write data while `req_ready` is high. The controller then drives the memory address, an active-low select (`mem_ce1_n`), an active-high select (`mem_ce2`), an active-low write strobe and an active-low output enable. It also controls the direction of the data bus. When the access ends it returns a one-cycle `done` pulse, and after a read it returns the captured byte on `rd_data`.

Each analogue timing minimum is a nanosecond parameter. It is turned into a clock-cycle count, `ceil(ns / CLK_NS)` with a floor of one cycle. The state machine has five states: IDLE, READ, WR_SETUP, WR_PULSE and WR_RECOVER. Its transitions are:
- **accept-read**: IDLE to READ.
- **accept-write**: IDLE to WR_SETUP.
- **read-end**: READ to IDLE.
- **setup-end**: WR_SETUP to WR_PULSE.
- **pulse-end**: WR_PULSE to WR_RECOVER.
- **recover-end**: WR_RECOVER to IDLE.

Each state lasts its own count. A single down-counter, reloaded on every transition, times all of them. With the defaults (20 ns clock, 70 ns part), a read holds READ for 4 cycles. A write spends 2 cycles in WR_SETUP, 3 in WR_PULSE and 1 in WR_RECOVER.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and right after reset, the controller drives the following: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `done`=0.
- R2: The memory is selected only by the pair `mem_ce1_n`=0, `mem_ce2`=1, and both enables always change together. In IDLE the memory is deselected.
- R3: A read holds READ for RD_CYC = max(ceil(T_RC/CLK), ceil(T_AA/CLK), ceil(T_DOE/CLK)) cycles. Throughout READ, `mem_oe_n`=0, `mem_we_n`=1, the bus is undriven and `mem_addr` equals the accepted address.
- R4: The byte on `mem_dq_in` is captured at the edge that ends the last READ cycle. In the next cycle, `done` is high for exactly one cycle and `rd_data` holds that byte.
- R5: A write first holds WR_SETUP for SU_CYC = ceil(T_HZOE/CLK) cycles. In WR_SETUP the memory is selected, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0, so the part's drivers have released before the controller drives.
- R6: WR_PULSE lasts max(ceil(T_PWE/CLK), ceil(T_SD/CLK), ceil(T_AW/CLK)−SU_CYC, ceil(T_SCE/CLK)−SU_CYC) cycles, with a floor of 1. In WR_PULSE, `mem_we_n`=0, `mem_dq_oe`=1 and `mem_dq_out` equals the accepted write data.
- R7: Every write ends with `mem_we_n` rising while both enables stay asserted. During WR_RECOVER (at least 1 cycle), the address and the write data stay driven.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R9: `req_ready` is high only in IDLE. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge, and `done` is high in the first IDLE cycle after each access.
- R10: From acceptance to `done`, a write keeps the memory selected for at least T_WC nanoseconds.
- R11: A `req_valid` raised while `req_ready` is low has no effect on the strobes, address or data of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request word address |
| req_wdata | input | 8 | Request write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 8 | Last captured read byte |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Active-low memory select |
| mem_ce2 | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The `done` pulse of one access falls in the same IDLE cycle in which the next request is accepted. This happens because IDLE is both the done cycle and the only cycle in which `req_ready` is high. The bench provokes this by issuing requests with zero gap after write-to-read, write-to-write and read-to-read pairs. It judges the overlap against a queue of expected per-cycle strobe patterns, so a collision must produce both the done pulse and the first cycle of the new access. The bench's memory model returns garbage until three read edges have passed, so a shortened read count shows up in `rd_data`.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } seq_state_e;

    // Round a nanosecond minimum up to whole clocks, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Remaining cycles after a leading phase, never below one.
    function automatic int unsigned remain(input int unsigned total, input int unsigned used);
        return (total > used) ? (total - used) : 1;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: an expired count stays expired until reloaded (no wrap)
    a_r3_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W   = 3,
    parameter int unsigned RD_CYC  = 4,
    parameter int unsigned SU_CYC  = 2,
    parameter int unsigned PW_CYC  = 3,
    parameter int unsigned REC_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             req_ready,
    output logic             accept,
    output logic             last_read,
    output logic             last_op,
    output logic             ce1_n,
    output logic             ce2,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    seq_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_READ;
            ST_READ:       if (expired)   state_d = ST_IDLE;
            ST_WR_SETUP:   if (expired)   state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (expired)   state_d = ST_WR_RECOVER;
            ST_WR_RECOVER: if (expired)   state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Timer reload on each transition with the duration of the entered state
    always_comb begin
        load     = (state_d != state_q);
        load_val = '0;
        unique case (state_d)
            ST_READ:       load_val = CNT_W'(RD_CYC - 1);
            ST_WR_SETUP:   load_val = CNT_W'(SU_CYC - 1);
            ST_WR_PULSE:   load_val = CNT_W'(PW_CYC - 1);
            ST_WR_RECOVER: load_val = CNT_W'(REC_CYC - 1);
            default:       load_val = '0;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign last_read = (state_q == ST_READ) && expired;
    assign last_op   = ((state_q == ST_READ) || (state_q == ST_WR_RECOVER)) && expired;

    // Outputs: registered from the next state so pins change on the same edge as state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce1_n <= 1'b1;
            ce2   <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce1_n <= (state_d == ST_IDLE);
            ce2   <= (state_d != ST_IDLE);
            oe_n  <= (state_d != ST_READ);
            we_n  <= (state_d != ST_WR_PULSE);
            dq_oe <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_RECOVER);
        end
    end

    // R7: write strobe only falls from the setup phase, never straight from idle or read
    a_r7_pulse_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(state_q == ST_WR_SETUP));

    // R9: a request is only taken out of idle
    a_r9_leave_idle_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              op_end,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= op_end;
            if (cap_en) begin
                rd_data <= dq_in;
            end
        end
    end

    // R4: done is a single-cycle pulse
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: captured data is held while no read ends
    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(rd_data));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 20,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_DOE_NS  = 35,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_SCE_NS  = 60,
    parameter int unsigned T_AW_NS   = 60,
    parameter int unsigned T_PWE_NS  = 55,
    parameter int unsigned T_SD_NS   = 30,
    parameter int unsigned T_HZOE_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned RD_CYC  = umax(umax(ns_to_cycles(T_RC_NS, CLK_NS),
                                                ns_to_cycles(T_AA_NS, CLK_NS)),
                                           ns_to_cycles(T_DOE_NS, CLK_NS));
    localparam int unsigned SU_CYC  = ns_to_cycles(T_HZOE_NS, CLK_NS);
    localparam int unsigned PW_CYC  = umax(umax(ns_to_cycles(T_PWE_NS, CLK_NS),
                                                ns_to_cycles(T_SD_NS, CLK_NS)),
                                           umax(remain(ns_to_cycles(T_AW_NS, CLK_NS), SU_CYC),
                                                remain(ns_to_cycles(T_SCE_NS, CLK_NS), SU_CYC)));
    localparam int unsigned REC_CYC = remain(ns_to_cycles(T_WC_NS, CLK_NS), SU_CYC + PW_CYC);
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, SU_CYC), umax(PW_CYC, REC_CYC));
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             load, expired, accept, last_read, last_op;
    logic [CNT_W-1:0] load_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Request hold registers: loaded only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    sram_cyc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .SU_CYC  (SU_CYC),
        .PW_CYC  (PW_CYC),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .req_ready (req_ready),
        .accept    (accept),
        .last_read (last_read),
        .last_op   (last_op),
        .ce1_n     (mem_ce1_n),
        .ce2       (mem_ce2),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (last_read),
        .op_end  (last_op),
        .dq_in   (mem_dq_in),
        .rd_data (rd_data),
        .done    (done)
    );

    // R8: never drive the bus while the memory may be driving it
    a_r8_no_drive_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R7: the write ends by the write strobe rising with both enables held
    a_r7_we_rises_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe));

    // R5: bus drive starts only after output enable was already high
    a_r5_drive_after_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // R6: write strobe low implies data is on the bus
    a_r6_we_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R2: the two selects move together
    a_r2_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n == !mem_ce2);

    // R11: address stays put while an access is in progress
    a_r11_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mem_addr));

endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;

    localparam int CLK_NS = 20;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase lengths from the requirements
    localparam int E_RD  = mx(mx(cyc(70), cyc(70)), cyc(35));
    localparam int E_SU  = cyc(25);
    localparam int E_PW  = mx(mx(cyc(55), cyc(30)), mx(mx(cyc(60) - E_SU, 1), mx(cyc(60) - E_SU, 1)));
    localparam int E_REC = mx(cyc(70) - E_SU - E_PW, 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    always #10 clk = ~clk;

    sram_cycle_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .done       (done),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_ce1_n  (mem_ce1_n),
        .mem_ce2    (mem_ce2),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // ---------------- behavioural memory ----------------
    logic [7:0] sram [int];
    int         rd_age = 0;
    logic       read_cond;

    function automatic logic [7:0] init_val(input logic [16:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    assign read_cond = !mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n;

    always @(posedge clk) rd_age <= read_cond ? rd_age + 1 : 0;

    always @(posedge mem_we_n) begin
        if (!mem_ce1_n && mem_ce2 && mem_dq_oe) sram[int'(mem_addr)] = mem_dq_out;
    end

    // Data is only valid once the access time has elapsed; garbage before that.
    always @* begin
        if (read_cond && rd_age >= 3)
            mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : init_val(mem_addr);
        else
            mem_dq_in = 8'hA5;
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit          rdy, sel, oe, we, drv, done, chk;
        int          ph;      // 0 idle, 1 read, 2 setup, 3 pulse, 4 recover
        bit          wr_end;
        logic [16:0] addr;
        logic [7:0]  data;
    } exp_t;

    exp_t       q[$];
    logic [7:0] shadow [int];
    int         checks = 0;
    int         errors = 0;
    int         wr_sel_cycles = 0;
    bit         finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic exp_t mk(input int ph, input logic [16:0] a, input logic [7:0] d);
        exp_t e;
        e.ph = ph; e.addr = a; e.data = d;
        e.rdy = (ph == 0); e.sel = (ph != 0); e.oe = (ph == 1);
        e.we = (ph == 3); e.drv = (ph == 3) || (ph == 4);
        e.done = 0; e.chk = 0; e.wr_end = 0;
        return e;
    endfunction

    function automatic string tag_of(input int ph);
        case (ph)
            1: return "R3";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic push_read(input logic [16:0] a);
        exp_t e;
        for (int i = 0; i < E_RD; i++) q.push_back(mk(1, a, 8'h00));
        e = mk(0, a, shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a));
        e.done = 1; e.chk = 1;
        q.push_back(e);
    endtask

    task automatic push_write(input logic [16:0] a, input logic [7:0] d);
        exp_t e;
        for (int i = 0; i < E_SU; i++)  q.push_back(mk(2, a, d));
        for (int i = 0; i < E_PW; i++)  q.push_back(mk(3, a, d));
        for (int i = 0; i < E_REC; i++) q.push_back(mk(4, a, d));
        e = mk(0, a, d);
        e.done = 1; e.wr_end = 1;
        q.push_back(e);
        shadow[int'(a)] = d;
    endtask

    task automatic compare(input exp_t e, input bit noisy);
        string t;
        t = tag_of(e.ph);
        check(req_ready == e.rdy, "R9", req_ready, e.rdy);
        check((mem_ce1_n == !e.sel) && (mem_ce2 == e.sel), "R2",
              {mem_ce1_n, mem_ce2}, {!e.sel, e.sel});
        check(mem_oe_n == !e.oe, t, mem_oe_n, !e.oe);
        check(mem_we_n == !e.we, t, mem_we_n, !e.we);
        check(mem_dq_oe == e.drv, t, mem_dq_oe, e.drv);
        check(!(mem_dq_oe && !mem_oe_n), "R8", {mem_dq_oe, mem_oe_n}, 2'b01);
        check(done == e.done, "R4", done, e.done);
        if (e.sel) check(mem_addr == e.addr, noisy ? "R11" : "R3", mem_addr, e.addr);
        if (e.drv) check(mem_dq_out == e.data, noisy ? "R11" : "R6", mem_dq_out, e.data);
        if (e.chk) check(rd_data == e.data, "R4", rd_data, e.data);
        if (e.ph >= 2 && !mem_ce1_n) wr_sel_cycles++;
        if (e.wr_end) begin
            check(wr_sel_cycles * CLK_NS >= 70, "R10", wr_sel_cycles * CLK_NS, 70);
            wr_sel_cycles = 0;
        end
    endtask

    // ---------------- program ----------------
    localparam int NOPS = 12;
    bit          op_w   [NOPS] = '{1, 0, 0, 1, 0, 1, 1, 0, 0, 0, 1, 0};
    logic [16:0] op_a   [NOPS] = '{17'h00010, 17'h00010, 17'h1FFFF, 17'h1FFFF, 17'h1FFFF,
                                   17'h00000, 17'h00001, 17'h00000, 17'h00001, 17'h12345,
                                   17'h12345, 17'h12345};
    logic [7:0]  op_d   [NOPS] = '{8'h5A, 8'h00, 8'h00, 8'h0F, 8'h00, 8'hFF, 8'h00,
                                   8'h00, 8'h00, 8'h00, 8'h81, 8'h00};
    int          op_gap [NOPS] = '{0, 0, 2, 1, 0, 3, 0, 0, 0, 1, 0, 0};
    bit          op_nz  [NOPS] = '{0, 0, 0, 1, 1, 0, 0, 0, 1, 0, 1, 0};

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        exp_t idle_e, e;
        int   opi, gap_left;
        bit   noisy;
        idle_e = mk(0, 17'h0, 8'h0);

        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        check(mem_ce1_n == 1 && mem_ce2 == 0, "R1", {mem_ce1_n, mem_ce2}, 2'b10);
        check(mem_we_n == 1 && mem_oe_n == 1, "R1", {mem_we_n, mem_oe_n}, 2'b11);
        check(mem_dq_oe == 0 && done == 0, "R1", {mem_dq_oe, done}, 2'b00);
        check(req_ready == 1, "R1", req_ready, 1);
        rst_n = 1'b1;

        opi = 0;
        gap_left = op_gap[0];
        noisy = 0;
        for (int cycle = 0; cycle < 400; cycle++) begin
            @(negedge clk);
            e = (q.size() != 0) ? q.pop_front() : idle_e;
            compare(e, noisy && !e.rdy);
            if (e.rdy) begin
                noisy = 0;
                if (opi < NOPS && gap_left == 0) begin
                    req_valid = 1'b1;
                    req_write = op_w[opi];
                    req_addr  = op_a[opi];
                    req_wdata = op_d[opi];
                    if (op_w[opi]) push_write(op_a[opi], op_d[opi]);
                    else           push_read(op_a[opi]);
                    noisy = op_nz[opi];
                    opi++;
                    if (opi < NOPS) gap_left = op_gap[opi];
                end else begin
                    if (gap_left > 0) gap_left--;
                    req_valid = 1'b0;
                end
            end else if (noisy) begin
                // R11: junk requests while busy
                req_valid = 1'b1;
                req_write = ~req_write;
                req_addr  = 17'h0AAAA ^ 17'(cycle);
                req_wdata = 8'h33 ^ 8'(cycle);
            end else begin
                req_valid = 1'b0;
            end
            if (opi == NOPS && q.size() == 0 && !req_valid) break;
        end
        check(opi == NOPS, "R9", opi, NOPS);
        finish_run();
    end

endmodule